// File: doc/BRIEF.md
# Reconfiguration host sequencer

This block runs one partial reconfiguration of a region of a programmable device at a time. A rising edge on the start input, seen while the block is idle, opens an operation. The block then raises freeze to isolate the region and asserts a request to the device's configuration port. When the port reports ready, it streams configuration words from a valid/ready source to the port's data pins. Each word goes out with a one-cycle strobe on the port clock pin. After the source marks the last word, the block waits for the port's done line. It also watches the port's error and CRC-error lines, and a drop of the port's ready line.

The outcome is held in a 3-bit status code that keeps its value after the operation is over. A new start edge seen while idle is the only thing that clears it. An optional single-cycle interrupt pulse marks the moment an operation reaches a final code. The reset is asynchronous and always enters a withdrawal state. If the reset hits an operation in flight, freeze stays high and the request stays low until the port's ready line falls. Only then does the block go idle.

The source data width (1, 8, 16 or 32 bits) and the port width (16 or 32 bits) are parameters, with the data width no wider than the port. The interrupt can be removed by a parameter.

Top module: `rcfg_sequencer`

## Requirements
- R1: While `rst_n` is low, `status_o` is 000, and `port_req_o`, `cfg_ready_o` and `irq_o` are low.
- R2: An operation starts only on a 0-to-1 change of `start_i` sampled while `freeze_o` is low. One cycle later, `status_o` is 100 (in progress) and `port_req_o` is high. Holding `start_i` high starts nothing more, and an edge during an operation is ignored.
- R3: `freeze_o` is high from the cycle after a start is accepted until the cycle after the operation ends, and low while idle. `port_req_o` is never high without `freeze_o`.
- R4: After the request, `cfg_ready_o` stays low until `port_ready_i` is high. `cfg_ready_o` is high only while words are being streamed and the port is ready.
- R5: A word moves on a rising edge where `cfg_valid_i` and `cfg_ready_o` are both high. In the next cycle, `port_data_o` holds the word zero-extended to the port width, and `port_clk_o` is high for that one cycle.
- R6: Once the word marked by `cfg_last_i` has moved, `cfg_ready_o` stays low and the block waits for `port_done_i`. Done then ends the operation with status 101 (pass) and drops `port_req_o`.
- R7: During streaming or the wait for done, `port_err_i` ends the operation at once with status 001. `port_crc_i` ends it with 010. When both are high, 001 wins.
- R8: If `port_ready_i` falls during streaming with no error line high, the operation ends with status 011 (incompatible image).
- R9: A final code (001, 010, 011, 101) stays on `status_o` until the next accepted start, which changes it straight to 100. Codes 110 and 111 never appear.
- R10: `irq_o` is high for exactly one cycle: the first cycle in which `status_o` shows a final code after 100. It is never high at any other time.
- R11: After reset is released, `port_req_o` and `cfg_ready_o` stay low and `freeze_o` stays high until `port_ready_i` is low. One cycle later the block is idle with status 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, up to 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, enters withdrawal |
| start_i | input | 1 | Operation trigger, acts on its rising edge |
| cfg_data_i | input | DATA_W | Configuration word from the source |
| cfg_valid_i | input | 1 | Source has a word |
| cfg_last_i | input | 1 | Marks the final word of the image |
| cfg_ready_o | output | 1 | Block accepts a word this cycle |
| freeze_o | output | 1 | Isolates the region while high |
| status_o | output | 3 | Latched outcome code |
| irq_o | output | 1 | One-cycle pulse on reaching a final code |
| port_ready_i | input | 1 | Configuration port is ready |
| port_done_i | input | 1 | Configuration port finished |
| port_err_i | input | 1 | Configuration port reports an error |
| port_crc_i | input | 1 | Configuration port reports a CRC error |
| port_req_o | output | 1 | Request to the configuration port |
| port_clk_o | output | 1 | Strobe that clocks a word into the port |
| port_data_o | output | PORT_W | Word presented to the port |

## Verification
The bench aims at the points where latching and priority can go wrong:
- It holds start high across and after an operation, and toggles it mid-operation. A design that decodes the level, or that accepts edges while busy, would start extra operations.
- It raises both error lines together, and it pulls the port's ready line low in the middle of the stream. A design with the wrong priority reports CRC instead of error, and a missing ready-drop check hangs until the watchdog fires.
- It waits after each failure to confirm the code is held.
- It resets in the middle of streaming while the port model holds its ready line high. A design without withdrawal would drop freeze or go idle at once, not when the ready line finally falls.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

   typedef enum logic [2:0] {
      ST_CLEAR  = 3'b000,
      ST_DEVERR = 3'b001,
      ST_CRCERR = 3'b010,
      ST_BADIMG = 3'b011,
      ST_BUSY   = 3'b100,
      ST_PASS   = 3'b101
   } status_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_REQ,
      S_STREAM,
      S_WAITD,
      S_WDRAW
   } state_t;

endpackage

// File: rtl/rcfg_trigger.sv
module rcfg_trigger (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic edge_o
);

   logic start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q <= 1'b0;
      else        start_q <= start_i;
   end

   assign edge_o = start_i & ~start_q;

endmodule

// File: rtl/rcfg_stream.sv
module rcfg_stream #(
   parameter int DATA_W = 16,
   parameter int PORT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [PORT_W-1:0] port_data_o,
   output logic              port_clk_o
);

   localparam int PAD_W = PORT_W - DATA_W;

   logic [PORT_W-1:0] wide;

   generate
      if (PAD_W == 0) begin : g_direct
         assign wide = data_i;
      end else begin : g_pad
         assign wide = {{PAD_W{1'b0}}, data_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_data_o <= '0;
         port_clk_o  <= 1'b0;
      end else begin
         port_clk_o <= accept_i;
         if (accept_i) port_data_o <= wide;
      end
   end

endmodule

// File: rtl/rcfg_ctrl.sv
module rcfg_ctrl
   import rcfg_pkg::*;
#(
   parameter bit IRQ_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       edge_i,
   input  logic       valid_i,
   input  logic       last_i,
   input  logic       port_ready_i,
   input  logic       port_done_i,
   input  logic       port_err_i,
   input  logic       port_crc_i,
   output logic       cfg_ready_o,
   output logic       accept_o,
   output logic       freeze_o,
   output logic       port_req_o,
   output logic [2:0] status_o,
   output logic       irq_o
);

   state_t  st_q, st_n;
   status_t sts_q, sts_n;
   logic    fault;
   status_t fault_code;

   assign fault      = port_err_i | port_crc_i;
   assign fault_code = port_err_i ? ST_DEVERR : ST_CRCERR;

   assign cfg_ready_o = (st_q == S_STREAM) & port_ready_i & ~fault;
   assign accept_o    = cfg_ready_o & valid_i;
   assign freeze_o    = (st_q != S_IDLE);
   assign port_req_o  = (st_q == S_REQ) | (st_q == S_STREAM) | (st_q == S_WAITD);
   assign status_o    = sts_q;

   always_comb begin
      st_n  = st_q;
      sts_n = sts_q;
      unique case (st_q)
         S_IDLE: begin
            if (edge_i) begin
               st_n  = S_REQ;
               sts_n = ST_BUSY;
            end
         end
         S_REQ: begin
            if (port_ready_i) st_n = S_STREAM;
         end
         S_STREAM: begin
            if (fault) begin
               st_n  = S_IDLE;
               sts_n = fault_code;
            end else if (!port_ready_i) begin
               st_n  = S_IDLE;
               sts_n = ST_BADIMG;
            end else if (accept_o && last_i) begin
               st_n = S_WAITD;
            end
         end
         S_WAITD: begin
            if (fault) begin
               st_n  = S_IDLE;
               sts_n = fault_code;
            end else if (port_done_i) begin
               st_n  = S_IDLE;
               sts_n = ST_PASS;
            end
         end
         S_WDRAW: begin
            if (!port_ready_i) st_n = S_IDLE;
         end
         default: st_n = S_WDRAW;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_WDRAW;
         sts_q <= ST_CLEAR;
      end else begin
         st_q  <= st_n;
         sts_q <= sts_n;
      end
   end

   generate
      if (IRQ_EN) begin : g_irq
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= (sts_q == ST_BUSY) && (sts_n != ST_BUSY);
         end
         assign irq_o = irq_q;
      end else begin : g_no_irq
         assign irq_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/rcfg_sequencer.sv
module rcfg_sequencer #(
   parameter int DATA_W = 16,
   parameter int PORT_W = 32,
   parameter bit IRQ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] cfg_data_i,
   input  logic              cfg_valid_i,
   input  logic              cfg_last_i,
   output logic              cfg_ready_o,
   output logic              freeze_o,
   output logic [2:0]        status_o,
   output logic              irq_o,
   input  logic              port_ready_i,
   input  logic              port_done_i,
   input  logic              port_err_i,
   input  logic              port_crc_i,
   output logic              port_req_o,
   output logic              port_clk_o,
   output logic [PORT_W-1:0] port_data_o
);

   initial begin
      a_data_w_legal: assert (DATA_W == 1 || DATA_W == 8 || DATA_W == 16 || DATA_W == 32)
         else $error("DATA_W must be 1, 8, 16 or 32");
      a_port_w_legal: assert ((PORT_W == 16 || PORT_W == 32) && DATA_W <= PORT_W)
         else $error("PORT_W must be 16 or 32 and not narrower than DATA_W");
   end

   logic start_edge;
   logic accept;

   rcfg_trigger u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .edge_o  (start_edge)
   );

   rcfg_ctrl #(.IRQ_EN(IRQ_EN)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .edge_i       (start_edge),
      .valid_i      (cfg_valid_i),
      .last_i       (cfg_last_i),
      .port_ready_i (port_ready_i),
      .port_done_i  (port_done_i),
      .port_err_i   (port_err_i),
      .port_crc_i   (port_crc_i),
      .cfg_ready_o  (cfg_ready_o),
      .accept_o     (accept),
      .freeze_o     (freeze_o),
      .port_req_o   (port_req_o),
      .status_o     (status_o),
      .irq_o        (irq_o)
   );

   rcfg_stream #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_stream (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .data_i      (cfg_data_i),
      .port_data_o (port_data_o),
      .port_clk_o  (port_clk_o)
   );

endmodule

// File: rtl/rcfg_checker.sv
module rcfg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       cfg_valid_i,
   input logic       cfg_ready_o,
   input logic       freeze_o,
   input logic [2:0] status_o,
   input logic       irq_o,
   input logic       port_ready_i,
   input logic       port_req_o,
   input logic       port_clk_o
);

   p_req_inside_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
      port_req_o |-> freeze_o);

   p_busy_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 3'b100) |-> freeze_o);

   p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready_o |-> (port_ready_i && port_req_o));

   p_strobe_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      port_clk_o |-> $past(cfg_valid_i && cfg_ready_o));

   p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_o) != 3'b100 && status_o == 3'b100) |-> ($past(start_i) && !$past(freeze_o)));

   p_legal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o != 3'b110 && status_o != 3'b111));

   p_final_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status_o) == 3'b001 || $past(status_o) == 3'b010 ||
        $past(status_o) == 3'b011 || $past(status_o) == 3'b101) &&
       status_o != $past(status_o)) |-> (status_o == 3'b100));

   p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(status_o) == 3'b100 && status_o != 3'b100 && status_o != 3'b000));

endmodule

bind rcfg_sequencer rcfg_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .cfg_valid_i  (cfg_valid_i),
   .cfg_ready_o  (cfg_ready_o),
   .freeze_o     (freeze_o),
   .status_o     (status_o),
   .irq_o        (irq_o),
   .port_ready_i (port_ready_i),
   .port_req_o   (port_req_o),
   .port_clk_o   (port_clk_o)
);

// File: tb/rcfg_sequencer_bench.sv
module rcfg_sequencer_bench;

   localparam int DW = 16;
   localparam int PW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          start_i = 1'b0;
   logic [DW-1:0] cfg_data_i = '0;
   logic          cfg_valid_i = 1'b0;
   logic          cfg_last_i = 1'b0;
   logic          cfg_ready_o;
   logic          freeze_o;
   logic [2:0]    status_o;
   logic          irq_o;
   logic          port_ready_i;
   logic          port_done_i = 1'b0;
   logic          port_err_i = 1'b0;
   logic          port_crc_i = 1'b0;
   logic          port_req_o;
   logic          port_clk_o;
   logic [PW-1:0] port_data_o;

   // configuration port model: ready follows request two cycles later
   logic rdy_d1 = 1'b0, rdy_d2 = 1'b0;
   logic stick = 1'b0, kill = 1'b0;
   always @(posedge clk) begin
      rdy_d1 <= port_req_o;
      rdy_d2 <= rdy_d1;
   end
   assign port_ready_i = (rdy_d2 | stick) & ~kill;

   always #4 clk = ~clk;

   rcfg_sequencer #(.DATA_W(DW), .PORT_W(PW), .IRQ_EN(1'b1)) u_rcfg_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cfg_data_i(cfg_data_i), .cfg_valid_i(cfg_valid_i), .cfg_last_i(cfg_last_i),
      .cfg_ready_o(cfg_ready_o), .freeze_o(freeze_o), .status_o(status_o), .irq_o(irq_o),
      .port_ready_i(port_ready_i), .port_done_i(port_done_i), .port_err_i(port_err_i),
      .port_crc_i(port_crc_i), .port_req_o(port_req_o), .port_clk_o(port_clk_o),
      .port_data_o(port_data_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [2:0]    exp_q[$];
   logic [PW-1:0] dq[$];
   logic [2:0]    last_st = 3'b000;
   bit            mon_on = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] pad(input logic [DW-1:0] w);
      logic [PW-1:0] r;
      r = '0;
      r[DW-1:0] = w;
      return r;
   endfunction

   // monitor: status scoreboard, interrupt and forwarded words
   always @(negedge clk) begin
      if (mon_on) begin
         if (status_o !== last_st) begin
            logic [2:0] e;
            logic       ei;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 unexpected status change", int'(status_o), int'(last_st));
            end else begin
               e  = exp_q.pop_front();
               ei = (last_st == 3'b100) &&
                    (e == 3'b001 || e == 3'b010 || e == 3'b011 || e == 3'b101);
               chk(status_o === e, "R9 status sequence", int'(status_o), int'(e));
               chk(irq_o === ei, "R10 irq on change", int'(irq_o), int'(ei));
            end
            last_st = status_o;
         end else if (irq_o !== 1'b0) begin
            chk(1'b0, "R10 irq without change", int'(irq_o), 0);
         end
         if (port_clk_o === 1'b1) begin
            if (dq.size() == 0) chk(1'b0, "R5 unexpected port strobe", 1, 0);
            else begin
               logic [PW-1:0] w;
               w = dq.pop_front();
               chk(port_data_o === w, "R5 port word", int'(port_data_o), int'(w));
            end
         end
      end
   end

   task automatic run_start(input bit hold);
      exp_q.push_back(3'b100);
      @(negedge clk); start_i = 1'b1;
      @(negedge clk);
      chk(freeze_o === 1'b1, "R3 freeze after start", int'(freeze_o), 1);
      chk(port_req_o === 1'b1, "R2 request after start", int'(port_req_o), 1);
      chk(cfg_ready_o === 1'b0, "R4 no ready before port", int'(cfg_ready_o), 0);
      if (!hold) start_i = 1'b0;
   endtask

   task automatic send_words(input int n, input logic [DW-1:0] base, input bit mark_last);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cfg_valid_i = 1'b1;
         cfg_data_i  = base + DW'(i);
         cfg_last_i  = mark_last && (i == n - 1);
         while (cfg_ready_o !== 1'b1) @(negedge clk);
         dq.push_back(pad(cfg_data_i));
         @(negedge clk);
         cfg_valid_i = 1'b0;
         cfg_last_i  = 1'b0;
         if (i % 2 == 1) @(negedge clk);
      end
   endtask

   task automatic finish_done();
      repeat (2) @(negedge clk);
      chk(freeze_o === 1'b1, "R6 still frozen awaiting done", int'(freeze_o), 1);
      chk(cfg_ready_o === 1'b0, "R6 no ready after last word", int'(cfg_ready_o), 0);
      exp_q.push_back(3'b101);
      port_done_i = 1'b1;
      @(negedge clk);
      port_done_i = 1'b0;
      chk(status_o === 3'b101, "R6 pass code", int'(status_o), 5);
      chk(freeze_o === 1'b0, "R3 freeze released", int'(freeze_o), 0);
      chk(port_req_o === 1'b0, "R6 request dropped", int'(port_req_o), 0);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(status_o === 3'b000, "R1 status in reset", int'(status_o), 0);
      chk(port_req_o === 1'b0, "R1 request in reset", int'(port_req_o), 0);
      chk(cfg_ready_o === 1'b0, "R1 ready in reset", int'(cfg_ready_o), 0);
      chk(irq_o === 1'b0, "R1 irq in reset", int'(irq_o), 0);
      mon_on = 1'b1;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(freeze_o === 1'b0, "R11 idle after power-up withdrawal", int'(freeze_o), 0);

      // plain pass
      run_start(1'b0);
      send_words(4, 16'h1200, 1'b1);
      finish_done();
      repeat (4) @(negedge clk);

      // start held high, extra edge mid-operation, no retrigger afterwards
      run_start(1'b1);
      send_words(2, 16'h3400, 1'b0);
      @(negedge clk); start_i = 1'b0;
      @(negedge clk); start_i = 1'b1;
      send_words(1, 16'h3402, 1'b1);
      finish_done();
      repeat (6) @(negedge clk);
      chk(status_o === 3'b101, "R2 held start no retrigger", int'(status_o), 5);
      chk(freeze_o === 1'b0, "R2 held start stays idle", int'(freeze_o), 0);
      start_i = 1'b0;
      repeat (3) @(negedge clk);

      // CRC error, then code held
      run_start(1'b0);
      send_words(2, 16'h5600, 1'b0);
      exp_q.push_back(3'b010);
      @(negedge clk); port_crc_i = 1'b1;
      @(negedge clk); port_crc_i = 1'b0;
      chk(status_o === 3'b010, "R7 crc code", int'(status_o), 2);
      chk(freeze_o === 1'b0, "R7 freeze dropped on crc", int'(freeze_o), 0);
      repeat (6) @(negedge clk);
      chk(status_o === 3'b010, "R9 crc code held", int'(status_o), 2);

      // both error lines during wait for done: device error wins
      run_start(1'b0);
      send_words(3, 16'h7800, 1'b1);
      @(negedge clk);
      exp_q.push_back(3'b001);
      port_err_i = 1'b1; port_crc_i = 1'b1;
      @(negedge clk); port_err_i = 1'b0; port_crc_i = 1'b0;
      chk(status_o === 3'b001, "R7 error beats crc", int'(status_o), 1);
      repeat (4) @(negedge clk);

      // port ready drops mid-stream
      run_start(1'b0);
      send_words(1, 16'h9A00, 1'b0);
      exp_q.push_back(3'b011);
      @(negedge clk); kill = 1'b1;
      @(negedge clk); kill = 1'b0;
      chk(status_o === 3'b011, "R8 incompatible code", int'(status_o), 3);
      repeat (5) @(negedge clk);
      chk(status_o === 3'b011, "R9 incompatible held", int'(status_o), 3);

      // reset in mid-stream while port keeps ready high
      run_start(1'b0);
      send_words(1, 16'hBC00, 1'b0);
      stick = 1'b1;
      exp_q.push_back(3'b000);
      #2 rst_n = 1'b0;
      @(negedge clk);
      chk(status_o === 3'b000, "R1 status cleared by reset", int'(status_o), 0);
      chk(port_req_o === 1'b0, "R1 request dropped by reset", int'(port_req_o), 0);
      #2 rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(freeze_o === 1'b1, "R11 frozen during withdrawal", int'(freeze_o), 1);
         chk(port_req_o === 1'b0, "R11 no request during withdrawal", int'(port_req_o), 0);
         chk(cfg_ready_o === 1'b0, "R11 no ready during withdrawal", int'(cfg_ready_o), 0);
      end
      stick = 1'b0;
      @(negedge clk);
      chk(freeze_o === 1'b0, "R11 idle once port ready falls", int'(freeze_o), 0);
      chk(status_o === 3'b000, "R11 status clear after withdrawal", int'(status_o), 0);

      // pass with all-ones words to check zero extension
      run_start(1'b0);
      send_words(2, 16'hFFFE, 1'b1);
      finish_done();
      repeat (3) @(negedge clk);

      chk(exp_q.size() == 0, "R9 all expected codes seen", exp_q.size(), 0);
      chk(dq.size() == 0, "R5 all words forwarded", dq.size(), 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule